// File: doc/BRIEF.md
# RAM Write-Protection Guard

This block sits between the memory-access path and a 12 kB on-chip RAM and decides, for every write, whether the write may reach the RAM. The RAM is cut into 32-byte blocks, and a bank of twelve 32-bit configuration words holds one protection bit per block. A CPU write carries a privilege flag. An unprivileged CPU write into a protected block is dropped and answered with a bus error. A privileged write always goes through. Reads are never stopped.

DMA writes follow a separate rule. They are only checked while a DMA-check enable bit is set. A blocked DMA write gets no bus error. Instead it sets a sticky interrupt flag and latches the faulting address. That address stays frozen until software clears the flag by writing a one to it.

Every access is a single-cycle request. The guard gives a combinational RAM write or read strobe in the same cycle, and a response strobe with the error flag one cycle later. Configuration is reached through a simple word-indexed register port with combinational read data.

Top module: `ramwp_guard`

## Requirements
- R1: Configuration indices 0 to 11 hold the protection map. Bit n of word k protects block 32*k+n, which covers byte offsets (32*k+n)*32 to (32*k+n)*32+31 from the RAM base. A set bit means protected. All words read back as written and are zero after reset.
- R2: The RAM window is 0x20000000 to 0x20002FFF. For a request outside it, ram_we and ram_re stay low and no bus error follows. Inside the window, ram_off gives the address minus the base (14 bits).
- R3: A CPU write (req_dma=0) with req_priv=0 to a protected block keeps ram_we low. The response in the next cycle carries bus_err=1, for that one cycle only.
- R4: A CPU write with req_priv=1 inside the window always raises ram_we and never gives a bus error, whatever the map says.
- R5: A read inside the window raises ram_re, never ram_we, and never leads to a bus error, in either privilege mode.
- R6: Configuration index 12, bit 0, enables the DMA check (reset 0; the other bits read 0). A DMA write ignores req_priv. With the check off, a DMA write inside the window always raises ram_we. With it on, a DMA write to a protected block keeps ram_we low, gives no bus error, and sets the interrupt flag from the next cycle.
- R7: Index 13 reads the fault address: the full request address of the DMA violation that set the flag. A later violation while the flag is already set does not change it.
- R8: Index 14, bit 0, reads the interrupt flag, and irq mirrors it. Writing a 1 to bit 0 clears the flag. Writing a 0 has no effect. A violation in the same cycle as a clear keeps the flag set.
- R9: resp_valid is high exactly one cycle after each cycle with req_valid high.
- R10: Configuration indices 15 and up read as zero. Writes to them, and writes to index 13, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_priv | input | 1 | CPU privileged mode |
| req_dma | input | 1 | Request comes from a DMA channel |
| req_addr | input | 32 | Byte address of the access |
| ram_we | output | 1 | Write strobe to the RAM |
| ram_re | output | 1 | Read strobe to the RAM |
| ram_off | output | 14 | Byte offset into the RAM |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| bus_err | output | 1 | Error flag on the response |
| irq | output | 1 | Management interrupt (sticky DMA fault flag) |

## Verification
The hardest case to reach is a DMA violation that lands in the same cycle as a software clear of the flag, while an earlier fault address is still latched. It needs the enable bit, a protected block, one earlier violation and an exactly aligned clear. A directed sequence builds this up step by step. First it raises one violation. Then it fires a second violation to a different address together with the clear. Then it checks that the flag survives and the first address stays. Random traffic then mixes map rewrites, enable toggles and clears with requests aimed at block edges and at both sides of the window.

// File: rtl/ramwp_pkg.sv
package ramwp_pkg;

    localparam logic [31:0] RAM_BASE_DEF  = 32'h2000_0000;
    localparam int          RAM_BYTES_DEF = 12288;
    localparam int          BLK_BYTES_DEF = 32;
    localparam int          REG_W_DEF     = 32;

    typedef enum logic [1:0] {
        V_NONE    = 2'd0,
        V_WRITE   = 2'd1,
        V_CPU_ERR = 2'd2,
        V_DMA_FLT = 2'd3
    } verdict_e;

    typedef struct packed {
        logic        valid;
        logic        write;
        logic        priv;
        logic        dma;
        logic [31:0] addr;
    } acc_t;

    function automatic verdict_e judge(acc_t a, logic in_win, logic prot, logic dma_en);
        verdict_e v;
        if (!a.valid || !a.write || !in_win)
            v = V_NONE;
        else if (prot && !a.dma && !a.priv)
            v = V_CPU_ERR;
        else if (prot && a.dma && dma_en)
            v = V_DMA_FLT;
        else
            v = V_WRITE;
        return v;
    endfunction

endpackage

// File: rtl/ramwp_decode.sv
module ramwp_decode #(
    parameter logic [31:0] RAM_BASE  = ramwp_pkg::RAM_BASE_DEF,
    parameter int          RAM_BYTES = ramwp_pkg::RAM_BYTES_DEF,
    parameter int          BLK_BYTES = ramwp_pkg::BLK_BYTES_DEF
) (
    input  logic [31:0]                                     addr,
    output logic                                            in_win,
    output logic [$clog2(RAM_BYTES)-1:0]                    off,
    output logic [$clog2(RAM_BYTES)-$clog2(BLK_BYTES)-1:0]  idx
);
    localparam int          OFF_W  = $clog2(RAM_BYTES);
    localparam int          BLK_SH = $clog2(BLK_BYTES);
    localparam logic [31:0] LIMIT  = RAM_BASE + 32'(RAM_BYTES);

    logic [31:0] rel;

    always_comb begin
        rel    = addr - RAM_BASE;
        in_win = (addr >= RAM_BASE) && (addr < LIMIT);
        off    = rel[OFF_W-1:0];
        idx    = rel[OFF_W-1:BLK_SH];
    end
endmodule

// File: rtl/ramwp_bitmap.sv
module ramwp_bitmap #(
    parameter int NREG   = 12,
    parameter int REG_W  = ramwp_pkg::REG_W_DEF,
    parameter int CFG_AW = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [REG_W-1:0]        cfg_wdata,
    output logic [NREG*REG_W-1:0]   map
);
    for (genvar k = 0; k < NREG; k++) begin : g_word
        logic [REG_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (cfg_wr && cfg_addr == CFG_AW'(k))
                word_q <= cfg_wdata;
        end
        assign map[k*REG_W +: REG_W] = word_q;
    end
endmodule

// File: rtl/ramwp_fault.sv
module ramwp_fault (
    input  logic        clk,
    input  logic        rst,
    input  logic        viol,
    input  logic [31:0] viol_addr,
    input  logic        clr,
    output logic        flag,
    output logic [31:0] faddr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            faddr <= '0;
        end else if (viol) begin
            flag <= 1'b1;
            if (!flag)
                faddr <= viol_addr;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ramwp_guard.sv
module ramwp_guard #(
    parameter logic [31:0] RAM_BASE  = ramwp_pkg::RAM_BASE_DEF,
    parameter int          RAM_BYTES = ramwp_pkg::RAM_BYTES_DEF,
    parameter int          BLK_BYTES = ramwp_pkg::BLK_BYTES_DEF,
    parameter int          REG_W     = ramwp_pkg::REG_W_DEF,
    parameter int          CFG_AW    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_wr,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [REG_W-1:0]              cfg_wdata,
    output logic [REG_W-1:0]              cfg_rdata,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic                          req_priv,
    input  logic                          req_dma,
    input  logic [31:0]                   req_addr,
    output logic                          ram_we,
    output logic                          ram_re,
    output logic [$clog2(RAM_BYTES)-1:0]  ram_off,
    output logic                          resp_valid,
    output logic                          bus_err,
    output logic                          irq
);
    import ramwp_pkg::*;

    localparam int NBLK     = RAM_BYTES / BLK_BYTES;
    localparam int NREG     = NBLK / REG_W;
    localparam int IDX_W    = $clog2(RAM_BYTES) - $clog2(BLK_BYTES);
    localparam int IX_CTRL  = NREG;
    localparam int IX_FADDR = NREG + 1;
    localparam int IX_STAT  = NREG + 2;

    logic [NREG*REG_W-1:0] map;
    logic                  in_win;
    logic [IDX_W-1:0]      idx;
    logic                  prot;
    logic                  dma_en_q;
    logic                  clr;
    logic                  flag;
    logic [31:0]           faddr;
    logic                  resp_q, err_q;
    acc_t                  acc;
    verdict_e              verdict;

    ramwp_bitmap #(.NREG(NREG), .REG_W(REG_W), .CFG_AW(CFG_AW)) u_map (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .map(map)
    );

    ramwp_decode #(.RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES), .BLK_BYTES(BLK_BYTES)) u_dec (
        .addr(req_addr), .in_win(in_win), .off(ram_off), .idx(idx)
    );

    ramwp_fault u_flt (
        .clk(clk), .rst(rst), .viol(verdict == V_DMA_FLT), .viol_addr(req_addr),
        .clr(clr), .flag(flag), .faddr(faddr)
    );

    always_comb begin
        acc     = '{valid: req_valid, write: req_write, priv: req_priv,
                    dma: req_dma, addr: req_addr};
        prot    = in_win && map[idx];
        verdict = judge(acc, in_win, prot, dma_en_q);
        ram_we  = (verdict == V_WRITE);
        ram_re  = req_valid && !req_write && in_win;
        clr     = cfg_wr && cfg_addr == CFG_AW'(IX_STAT) && cfg_wdata[0];
    end

    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < NREG; k++)
            if (cfg_addr == CFG_AW'(k))
                cfg_rdata = map[k*REG_W +: REG_W];
        if (cfg_addr == CFG_AW'(IX_CTRL))
            cfg_rdata = REG_W'(dma_en_q);
        if (cfg_addr == CFG_AW'(IX_FADDR))
            cfg_rdata = REG_W'(faddr);
        if (cfg_addr == CFG_AW'(IX_STAT))
            cfg_rdata = REG_W'(flag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_en_q <= 1'b0;
            resp_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (cfg_wr && cfg_addr == CFG_AW'(IX_CTRL))
                dma_en_q <= cfg_wdata[0];
            resp_q <= req_valid;
            err_q  <= (verdict == V_CPU_ERR);
        end
    end

    assign resp_valid = resp_q;
    assign bus_err    = err_q;
    assign irq        = flag;
endmodule

// File: rtl/ramwp_guard_chk.sv
module ramwp_guard_chk #(
    parameter logic [31:0] RAM_BASE  = 32'h2000_0000,
    parameter int          RAM_BYTES = 12288
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_priv,
    input logic        req_dma,
    input logic [31:0] req_addr,
    input logic        ram_we,
    input logic        ram_re,
    input logic        resp_valid,
    input logic        bus_err,
    input logic        irq,
    input logic        dma_en,
    input logic [31:0] faddr
);
    logic win;
    assign win = (req_addr >= RAM_BASE) && (req_addr - RAM_BASE < 32'(RAM_BYTES));

    a_r3_err_source: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(req_valid && req_write && !req_priv && !req_dma));

    a_r3_err_no_write: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> !$past(ram_we));

    a_r4_priv_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_priv && !req_dma && win) |-> ram_we);

    a_r2_outside: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !win) |-> (!ram_we && !ram_re));

    a_r5_read_no_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> !bus_err);

    a_r6_dma_off: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_dma && !dma_en && win) |-> ram_we);

    a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(req_valid && req_write && req_dma && dma_en && !ram_we));

    a_r7_fault_hold: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(irq)) |-> $stable(faddr));

    a_r9_resp: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
endmodule

bind ramwp_guard ramwp_guard_chk #(.RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_priv(req_priv), .req_dma(req_dma), .req_addr(req_addr),
    .ram_we(ram_we), .ram_re(ram_re), .resp_valid(resp_valid),
    .bus_err(bus_err), .irq(irq), .dma_en(dma_en_q), .faddr(faddr)
);

// File: tb/tb_ramwp_guard.sv
module tb_ramwp_guard;
    localparam logic [31:0] BASE  = 32'h2000_0000;
    localparam int          BYTES = 12288;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        req_valid, req_write, req_priv, req_dma;
    logic [31:0] req_addr;
    logic        ram_we, ram_re;
    logic [13:0] ram_off;
    logic        resp_valid, bus_err, irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    bit          m_map [384];
    bit          m_en;
    bit          m_flag;
    logic [31:0] m_faddr;

    always #5 clk = ~clk;

    ramwp_guard dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_priv(req_priv), .req_dma(req_dma),
        .req_addr(req_addr), .ram_we(ram_we), .ram_re(ram_re), .ram_off(ram_off),
        .resp_valid(resp_valid), .bus_err(bus_err), .irq(irq)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_win(logic [31:0] a);
        return (a >= BASE) && (a < BASE + 32'(BYTES));
    endfunction

    function automatic bit m_prot(logic [31:0] a);
        logic [31:0] r;
        r = a - BASE;
        return m_win(a) && m_map[r / 32];
    endfunction

    function automatic logic [31:0] m_rd(int ix);
        logic [31:0] w;
        w = '0;
        if (ix < 12) begin
            for (int b = 0; b < 32; b++) w[b] = m_map[ix*32 + b];
        end else if (ix == 12) w = {31'b0, m_en};
        else if (ix == 13) w = m_faddr;
        else if (ix == 14) w = {31'b0, m_flag};
        return w;
    endfunction

    function automatic string rd_tag(int ix);
        if (ix < 12) return "R1";
        if (ix == 12) return "R6";
        if (ix == 13) return "R7";
        if (ix == 14) return "R8";
        return "R10";
    endfunction

    // one clock of stimulus, comparing every output against the model
    task automatic step(bit w, int ca, logic [31:0] cd, bit v, bit wr, bit pv, bit dm,
                        logic [31:0] ad);
        bit    cpu_err, dma_flt, exp_we, exp_re;
        string tag;
        @(negedge clk);
        cfg_wr = w; cfg_addr = 4'(ca); cfg_wdata = cd;
        req_valid = v; req_write = wr; req_priv = pv; req_dma = dm; req_addr = ad;
        #1;
        cpu_err = v && wr && m_win(ad) && m_prot(ad) && !dm && !pv;
        dma_flt = v && wr && m_win(ad) && m_prot(ad) && dm && m_en;
        exp_we  = v && wr && m_win(ad) && !cpu_err && !dma_flt;
        exp_re  = v && !wr && m_win(ad);
        if (!m_win(ad)) tag = "R2";
        else if (!wr) tag = "R5";
        else if (dm) tag = "R6";
        else if (pv) tag = "R4";
        else tag = "R3";
        chk(tag, "ram_we", 32'(ram_we), 32'(exp_we));
        chk(tag, "ram_re", 32'(ram_re), 32'(exp_re));
        if (v && m_win(ad)) chk("R2", "ram_off", 32'(ram_off), 32'((ad - BASE) & 32'h3FFF));
        chk(rd_tag(ca), "cfg_rdata", cfg_rdata, m_rd(ca));
        @(posedge clk);
        if (w) begin
            if (ca < 12) for (int b = 0; b < 32; b++) m_map[ca*32 + b] = cd[b];
            if (ca == 12) m_en = cd[0];
        end
        if (dma_flt) begin
            if (!m_flag) m_faddr = ad;
            m_flag = 1'b1;
        end else if (w && ca == 14 && cd[0]) begin
            m_flag = 1'b0;
        end
        #1;
        chk("R9", "resp_valid", 32'(resp_valid), 32'(v));
        chk("R3", "bus_err", 32'(bus_err), 32'(cpu_err));
        chk("R8", "irq", 32'(irq), 32'(m_flag));
    endtask

    task automatic acc(bit wr, bit pv, bit dm, logic [31:0] ad);
        step(0, 15, '0, 1, wr, pv, dm, ad);
    endtask

    task automatic cfg(int ix, logic [31:0] d);
        step(1, ix, d, 0, 0, 0, 0, '0);
    endtask

    task automatic rd(int ix);
        step(0, ix, '0, 0, 0, 0, 0, '0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 384; i++) m_map[i] = 0;
        m_en = 0; m_flag = 0; m_faddr = '0;
        rst = 1; cfg_wr = 0; cfg_addr = '0; cfg_wdata = '0;
        req_valid = 0; req_write = 0; req_priv = 0; req_dma = 0; req_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset resp_valid", 32'(resp_valid), 0);
        chk("R3", "reset bus_err", 32'(bus_err), 0);
        chk("R8", "reset irq", 32'(irq), 0);
        @(negedge clk);
        rst = 0;

        // R1: reset values of every index
        for (int i = 0; i < 16; i++) rd(i);

        // R1: map words, R10: unused and read-only indices ignore writes
        cfg(0, 32'h0000_0005);
        cfg(11, 32'h8000_0001);
        cfg(5, 32'hA5A5_0F0F);
        cfg(15, 32'hFFFF_FFFF);
        cfg(13, 32'hDEAD_BEEF);
        for (int i = 0; i < 16; i++) rd(i);

        // R3: unprivileged CPU writes at block edges
        acc(1, 0, 0, BASE);
        acc(1, 0, 0, BASE + 32'h20);
        acc(1, 0, 0, BASE + 32'h5F);
        acc(1, 0, 0, BASE + 32'h2FE0);
        acc(1, 0, 0, BASE + 32'h2C00);
        acc(1, 0, 0, BASE + 32'h2BFF);
        // R2: just outside the window
        acc(1, 0, 0, BASE + 32'h3000);
        acc(1, 0, 0, BASE - 1);
        acc(0, 0, 0, BASE + 32'h3000);
        // R4: privileged writes pass
        acc(1, 1, 0, BASE);
        acc(1, 1, 0, BASE + 32'h2FFF);
        // R5: reads of protected blocks
        acc(0, 0, 0, BASE + 32'h40);
        acc(0, 1, 0, BASE);

        // R6: DMA unchecked while the enable is clear
        acc(1, 0, 1, BASE + 32'h44);
        cfg(12, 32'hFFFF_FFFF);
        rd(12);
        acc(1, 0, 1, BASE + 32'h20);
        acc(1, 1, 1, BASE + 32'h44);
        // R7: a second violation keeps the first address
        acc(1, 0, 1, BASE + 32'h2FE4);
        rd(13);
        // R8: writing zero does nothing, writing one clears
        cfg(14, 32'h0000_0000);
        rd(14);
        cfg(14, 32'h0000_0001);
        rd(14);
        // R8: violation A, then clear together with violation B
        acc(1, 0, 1, BASE + 32'h1);
        step(1, 14, 32'h1, 1, 1, 0, 1, BASE + 32'h2FF0);
        rd(13);
        rd(14);
        cfg(14, 32'h1);
        acc(1, 0, 1, BASE + 32'h2FF0);
        rd(13);
        cfg(14, 32'h1);
        cfg(12, 32'h0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a;
            int          sel;
            sel = int'($urandom % 10);
            if (sel < 7) a = BASE + ($urandom % 32'(BYTES));
            else if (sel == 7) a = BASE - 32'd64 + ($urandom % 32'd64);
            else if (sel == 8) a = BASE + 32'(BYTES) + ($urandom % 32'd64);
            else a = BASE + 32'h2FE0 + ($urandom % 32'd32);
            if ($urandom % 8 == 0)
                step(1, int'($urandom % 16), $urandom, $urandom % 2 == 0,
                     1'($urandom), 1'($urandom), 1'($urandom), a);
            else
                step(0, int'($urandom % 16), '0, $urandom % 4 != 0,
                     1'($urandom), 1'($urandom), 1'($urandom), a);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule